// File: doc/BRIEF.md
# Dark-Row Black Level Estimator

This block sits in a raster pixel stream of unsigned samples and removes the black-level offset within each frame. The first rows of every frame come from optically shielded pixels. While those rows stream past, the block sums the samples that qualify and counts them. A sample qualifies when its row is not masked off, it is not a hot pixel, and the sample cap has not been reached. At the end of the last shielded row, a sequential divider turns the sum and the count into a mean. That mean is subtracted from every later pixel of the same frame, and the result is clamped at zero. The shielded rows themselves leave the block unchanged.

Both streams use valid/ready handshakes. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. An output beat is delivered on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output beat and its markers hold steady. The output register has one slot, so back-pressure reaches the input within the same cycle. The input is also held off for a short window after the last shielded row, while the mean is being formed. During that window, only beats that start a new frame are accepted. `in_sof` marks the first beat of a frame and `in_eol` marks the last beat of a row. Both markers travel with the data.

Top module: `dkl_black_level`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the stored black level is 0. A first frame whose shielded rows give no usable sample passes its later pixels unchanged.
- R2: Pixels of the first DARK_ROWS rows (default 12) pass to the output unchanged.
- R3: A pixel after the shielded rows leaves as max(pixel − level, 0). Here level = floor(sum / count) over the qualifying shielded samples of the same frame.
- R4: A shielded sample whose top HOT_BITS bits (default 4, bits 11..8) are all ones is left out of both the sum and the count.
- R5: Bit i of `row_mask` set to 1 removes shielded row i (row 0 is the row that starts with `in_sof`) from the estimate.
- R6: Only the first MAX_SAMPLES qualifying samples of a frame (default 8096) are summed. Later samples have no effect on the level.
- R7: If a frame provides no qualifying sample, the level from the previous frame is kept.
- R8: With `enable` low, all pixels pass unchanged. The level is still computed and kept for later frames.
- R9: An accepted beat appears at the output on the next clock edge, one cycle of latency. It is held stable while `out_ready` is low.
- R10: A beat with `in_sof` restarts the sum, the count and the row position, so one frame's estimate never mixes with another's.
- R11: After the last shielded row ends, `in_ready` stays low for non-frame-start beats for at least 1 and at most SUM_W+3 cycles (28 by default). The new level is applied from the first pixel after that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 = subtract level from later rows, 0 = bypass |
| row_mask | input | DARK_ROWS | 1 in bit i excludes shielded row i from the estimate |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eol | input | 1 | Beat is the last of a row |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | PIX_W | Corrected pixel |
| out_sof | output | 1 | Frame-start marker, delayed with the data |
| out_eol | output | 1 | Row-end marker, delayed with the data |

## Verification
The mean is tested with several shielded-row contents: flat values with a fractional mean, which checks that the result is floored; a mix that contains hot pixels and near-hot values one code below the rejection threshold; and masked rows filled with large values, which would shift the mean if they were counted. One frame has more shielded samples than the cap, and the values past the cap are very different from those before it, so a missing cap shows up in the level. Further frames cover an all-hot shielded area after reset and after a valid frame, which separates a kept level from a zero or freshly computed one, and a bypass frame followed by a normal frame. Active-row values fall both above and below the level, so both the subtraction and the clamp are exercised. One frame runs against a periodic back-pressure pattern. A single-beat probe shows the one-cycle latency.

// File: rtl/dkl_pkg.sv
package dkl_pkg;
  typedef enum logic {REG_DARK = 1'b0, REG_LIVE = 1'b1} region_e;

  function automatic int cnt_bits(input int max_samples);
    return $clog2(max_samples + 1);
  endfunction
endpackage

// File: rtl/dkl_dark_acc.sv
module dkl_dark_acc #(
  parameter int PIX_W       = 12,
  parameter int HOT_BITS    = 4,
  parameter int MAX_SAMPLES = 8096,
  parameter int CNT_W       = 13,
  parameter int SUM_W       = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             dark,
  input  logic             masked,
  input  logic [PIX_W-1:0] data,
  output logic [SUM_W-1:0] sum,
  output logic [CNT_W-1:0] count
);
  logic hot, room, take;

  assign hot  = &data[PIX_W-1 -: HOT_BITS];
  assign room = sof || (count < CNT_W'(MAX_SAMPLES));
  assign take = beat && dark && !masked && !hot && room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum   <= '0;
      count <= '0;
    end else if (beat && sof) begin
      sum   <= take ? SUM_W'(data) : '0;
      count <= take ? CNT_W'(1) : '0;
    end else if (take) begin
      sum   <= sum + SUM_W'(data);
      count <= count + CNT_W'(1);
    end
  end

  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_SAMPLES));
  a_r4_hot_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !sof && hot |=> $stable(count) && $stable(sum));
  a_r10_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
    beat && sof |=> count <= CNT_W'(1));
endmodule

// File: rtl/dkl_seq_div.sv
module dkl_seq_div #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 13,
  parameter int Q_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quot
);
  localparam int CTR_W = $clog2(NUM_W);

  logic [NUM_W-1:0] quo;
  logic [DEN_W-1:0] rem, dvs;
  logic [CTR_W-1:0] ctr;
  logic [DEN_W:0]   trial;
  logic             fit;

  assign trial = {rem, quo[NUM_W-1]};
  assign fit   = trial >= {1'b0, dvs};
  assign quot  = quo[Q_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo  <= '0;
      rem  <= '0;
      dvs  <= '0;
      ctr  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        quo  <= num;
        rem  <= '0;
        dvs  <= den;
        ctr  <= CTR_W'(NUM_W - 1);
        busy <= 1'b1;
      end else if (busy) begin
        rem <= fit ? DEN_W'(trial - {1'b0, dvs}) : trial[DEN_W-1:0];
        quo <= {quo[NUM_W-2:0], fit};
        ctr <= ctr - CTR_W'(1);
        if (ctr == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r11_div_ends: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctr == '0 |=> done && !busy);
  a_r3_mean_fits: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (quo >> Q_W) == '0);
endmodule

// File: rtl/dkl_out_stage.sv
module dkl_out_stage #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             apply,
  input  logic [PIX_W-1:0] data,
  input  logic             sof,
  input  logic             eol,
  input  logic [PIX_W-1:0] level,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eol
);
  logic [PIX_W-1:0] corrected;

  assign corrected = (data > level) ? data - level : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (beat) begin
      out_valid <= 1'b1;
      out_data  <= apply ? corrected : data;
      out_sof   <= sof;
      out_eol   <= eol;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));
  a_r3_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> out_valid && out_data <= $past(data));
endmodule

// File: rtl/dkl_black_level.sv
module dkl_black_level #(
  parameter int PIX_W       = 12,
  parameter int DARK_ROWS   = 12,
  parameter int MAX_SAMPLES = 8096,
  parameter int HOT_BITS    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [DARK_ROWS-1:0] row_mask,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PIX_W-1:0]     in_data,
  input  logic                 in_sof,
  input  logic                 in_eol,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PIX_W-1:0]     out_data,
  output logic                 out_sof,
  output logic                 out_eol
);
  import dkl_pkg::*;

  localparam int CNT_W = cnt_bits(MAX_SAMPLES);
  localparam int SUM_W = PIX_W + CNT_W;
  localparam int ROW_W = $clog2(DARK_ROWS + 1);

  logic [ROW_W-1:0] row_q, row_eff;
  region_e          region;
  logic             beat, masked, last_dark, start_q, pending;
  logic             div_busy, div_done;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] count;
  logic [PIX_W-1:0] mean, level;

  assign row_eff = in_sof ? '0 : row_q;
  assign region  = (row_eff < ROW_W'(DARK_ROWS)) ? REG_DARK : REG_LIVE;
  assign pending = start_q || div_busy || div_done;
  assign in_ready = (!out_valid || out_ready) && !(pending && region == REG_LIVE);
  assign beat     = in_valid && in_ready;
  assign last_dark = beat && in_eol && (row_eff == ROW_W'(DARK_ROWS - 1));

  always_comb begin
    masked = 1'b0;
    for (int r = 0; r < DARK_ROWS; r++)
      if (row_eff == ROW_W'(r) && row_mask[r]) masked = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      start_q <= 1'b0;
      level   <= '0;
    end else begin
      start_q <= last_dark;
      if (beat && in_eol && region == REG_DARK) row_q <= row_eff + ROW_W'(1);
      else if (beat) row_q <= row_eff;
      if (div_done) level <= mean;
    end
  end

  dkl_dark_acc #(
    .PIX_W(PIX_W), .HOT_BITS(HOT_BITS), .MAX_SAMPLES(MAX_SAMPLES),
    .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .dark(region == REG_DARK), .masked(masked), .data(in_data),
    .sum(sum), .count(count)
  );

  dkl_seq_div #(.NUM_W(SUM_W), .DEN_W(CNT_W), .Q_W(PIX_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start_q && count != '0),
    .num(sum), .den(count), .busy(div_busy), .done(div_done), .quot(mean)
  );

  dkl_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .apply(enable && region == REG_LIVE), .data(in_data),
    .sof(in_sof), .eol(in_eol), .level(level), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol)
  );

  a_r11_stall_live: assert property (@(posedge clk) disable iff (!rst_n)
    pending && region == REG_LIVE |-> !in_ready);
  a_r7_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !div_done |=> $stable(level));
  a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/tb_dkl_black_level.sv
module tb_dkl_black_level;
  localparam int PIX_W = 12;
  localparam int DARK  = 12;
  localparam int MAXS  = 8096;
  localparam int SUM_W = PIX_W + $clog2(MAXS + 1);

  logic clk = 0, rst_n = 0, enable = 1;
  logic [DARK-1:0] row_mask = '0;
  logic in_valid = 0, in_sof = 0, in_eol = 0, out_ready = 1;
  logic [PIX_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [PIX_W-1:0] out_data;

  int checks = 0, fails = 0, prev_level = 0, max_stall = 0;
  bit bp = 0;
  int pix[];
  int got[$];

  always #2.5 clk = ~clk;

  dkl_black_level dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .row_mask(row_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol)
  );

  always begin
    @(negedge clk); #2;
    if (out_valid && out_ready) got.push_back(int'(out_data));
  end

  int bp_ctr = 0;
  always @(posedge clk) begin
    #1;
    bp_ctr++;
    out_ready = bp ? (bp_ctr % 3 != 0) : 1'b1;
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    report();
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int v, input bit s, input bit e);
    int stall = 0;
    @(negedge clk);
    in_valid = 1; in_data = PIX_W'(v); in_sof = s; in_eol = e;
    #1;
    while (!in_ready) begin
      stall++;
      @(negedge clk); #1;
    end
    if (stall > max_stall) max_stall = stall;
  endtask

  task automatic run_frame(input int rows, input int w, input string rd, input string ra);
    int n = rows * w, sum = 0, cnt = 0, lvl, bad_d = 0, bad_a = 0, ad = 0, ea = 0, ed = 0, aa = 0;
    int exp[];
    exp = new[n];
    for (int r = 0; r < DARK; r++)
      if (!row_mask[r])
        for (int c = 0; c < w; c++) begin
          int v = pix[r*w + c];
          if ((v >> 8) != 15 && cnt < MAXS) begin sum += v; cnt++; end
        end
    lvl = (cnt != 0) ? sum / cnt : prev_level;
    prev_level = lvl;
    for (int i = 0; i < n; i++)
      exp[i] = (i / w < DARK || !enable) ? pix[i] : (pix[i] > lvl ? pix[i] - lvl : 0);
    got.delete();
    max_stall = 0;
    for (int i = 0; i < n; i++) push(pix[i], i == 0, (i % w) == w - 1);
    @(negedge clk); in_valid = 0; in_sof = 0; in_eol = 0;
    for (int k = 0; k < 500 && got.size() < n; k++) @(negedge clk);
    check({rd, " output count"}, got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++) begin
      if (i / w < DARK) begin
        if (got[i] != exp[i] && bad_d == 0) begin bad_d = 1; ad = got[i]; ed = exp[i]; end
      end else if (got[i] != exp[i] && bad_a == 0) begin bad_a = 1; aa = got[i]; ea = exp[i]; end
    end
    checks++;
    if (bad_d) begin fails++; $display("FAIL %s: dark pixel actual=%0d expected=%0d", rd, ad, ed); end
    checks++;
    if (bad_a) begin fails++; $display("FAIL %s: active pixel actual=%0d expected=%0d (level %0d)", ra, aa, ea, lvl); end
  endtask

  // R1: reset state, and a first frame with only hot dark samples keeps level 0
  task automatic t_reset();
    #1;
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    pix = new[16 * 6];
    foreach (pix[i]) pix[i] = (i / 6 < DARK) ? 4095 - (i % 3) : 40 + 37 * i;
    run_frame(16, 6, "R1 dark", "R1 zero level");
  endtask

  // R9: single beat appears one cycle after acceptance
  task automatic t_latency();
    push(55, 1, 0);
    check("R9 no output before edge", int'(out_valid), 0);
    @(negedge clk); #2;
    check("R9 out_valid one cycle later", int'(out_valid), 1);
    check("R9 data one cycle later", int'(out_data), 55);
    check("R9 sof carried", int'(out_sof), 1);
    in_valid = 0; in_sof = 0;
    repeat (3) @(negedge clk);
  endtask

  // R2 R3 R10 R11: flat dark rows with fractional mean, active above and below it
  task automatic t_basic(input int base, input string tag);
    pix = new[16 * 8];
    foreach (pix[i]) pix[i] = (i / 8 < DARK) ? base + (i % 4) : ((i % 8) * 200 + i / 8) % 4096;
    run_frame(16, 8, {"R2 ", tag}, {"R3 R10 ", tag});
    check("R11 stall seen", int'(max_stall > 0), 1);
    check("R11 stall bounded", int'(max_stall <= SUM_W + 3), 1);
  endtask

  // R4: hot samples and a near-hot sample one code under the threshold
  task automatic t_hot();
    pix = new[14 * 8];
    foreach (pix[i]) begin
      int c = i % 8;
      pix[i] = (i / 8 < DARK) ? (c == 0 ? 12'hF05 : (c == 1 ? 12'hEFF : 200)) : 300 + 90 * c;
    end
    run_frame(14, 8, "R4 dark", "R4 hot rejected");
  endtask

  // R5: masked rows carry large values
  task automatic t_mask();
    row_mask = 12'b1000_0000_0101;
    pix = new[14 * 8];
    foreach (pix[i]) begin
      int r = i / 8;
      pix[i] = (r < DARK) ? ((r == 0 || r == 2 || r == 11) ? 3000 : 300 + (i % 3)) : 250 + 20 * (i % 8);
    end
    run_frame(14, 8, "R5 dark", "R5 masked rows");
    row_mask = '0;
  endtask

  // R7: all dark samples hot after a valid frame
  task automatic t_keep();
    pix = new[14 * 8];
    foreach (pix[i]) pix[i] = (i / 8 < DARK) ? 12'hFF0 + (i % 15) : 100 + 60 * (i % 8);
    run_frame(14, 8, "R7 dark", "R7 level kept");
  endtask

  // R8: bypass, level still computed for the next frame
  task automatic t_bypass();
    enable = 0;
    pix = new[14 * 8];
    foreach (pix[i]) pix[i] = (i / 8 < DARK) ? 777 : 50 * (i % 8);
    run_frame(14, 8, "R8 dark", "R8 bypass");
    enable = 1;
    pix = new[14 * 8];
    foreach (pix[i]) pix[i] = (i / 8 < DARK) ? 12'hFFF : 700 + 30 * (i % 8);
    run_frame(14, 8, "R8 dark next", "R8 level from bypass frame");
  endtask

  // R6: more qualifying samples than the cap, later ones very different
  task automatic t_cap();
    pix = new[13 * 700];
    foreach (pix[i]) pix[i] = (i / 700 < DARK) ? (i < MAXS ? 60 : 3000) : 100 + (i % 50);
    run_frame(13, 700, "R6 dark", "R6 sample cap");
  endtask

  // R9: back-pressure pattern during a whole frame
  task automatic t_bp();
    bp = 1;
    t_basic(420, "R9 backpressure");
    bp = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_latency();
    t_basic(100, "frame A");
    t_basic(900, "frame B");
    t_hot();
    t_mask();
    t_keep();
    t_bypass();
    t_cap();
    t_bp();
    report();
  end
endmodule